// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block fetches transmit work from a ring of buffer descriptors held in shared memory and turns it into a byte stream for a downstream MAC. Software fills in descriptors, points the engine at the start of the ring and rings a doorbell. For each descriptor marked ready, the engine reads the buffer word by word and sends its bytes out. It then clears the ready mark in memory and moves on. The walk stops at the first descriptor that is not ready. That descriptor's address is kept, and the next doorbell resumes from there.

A frame may span several descriptors and closes on the one that carries the last-buffer flag. The engine limits a frame to 2032 bytes: any excess is dropped and flagged. It reports three kinds of event as single-cycle pulses. One marks each descriptor it finishes, one marks each frame it completes, and one marks each descriptor that was truncated.

Each descriptor is two 32-bit words. In memory, the first word holds the flags in bits 31:16 and the byte length in bits 15:0. The second word holds the buffer address. Within the flags field, bit 15 marks the descriptor as ready, bit 13 is wrap, and bit 11 is last buffer.

Top module: `tx_ring_dma`

## Requirements
- R1: While rst_ni is low and after its release, mem_req_o, tx_valid_o, tx_sof_o, tx_eof_o and the three event outputs are all low, the ring base is 0 and the current pointer is 0.
- R2: A doorbell_i pulse is acted on only if en_i is high in the same cycle. Otherwise it causes no memory request and no output.
- R3: A walk step reads the word at the current pointer (flags in bits 31:16, length in bits 15:0), then the word at pointer+4 (buffer address, low two bits ignored). It then reads the buffer with word accesses, emitting one byte per cycle with bits 31:24 first. A length that is not a multiple of four uses only the leading bytes of the final word. The request, address and direction are held until mem_ack_i.
- R4: A descriptor whose flag bit 15 is clear ends the walk with no write, and its address becomes the start point for the next doorbell.
- R5: After a ready descriptor's bytes, the engine writes its first word back to the same address. Flag bit 15 is cleared and all other bits are unchanged. ev_buf_o pulses in the cycle after that write is acknowledged.
- R6: tx_sof_o marks the first byte of a frame. A descriptor with flag bit 11 set closes the frame: tx_eof_o marks its final byte, ev_frame_o pulses with its ev_buf_o, and the frame byte count returns to zero.
- R7: After a descriptor with flag bit 13 set, the next descriptor address is the ring base. Otherwise it is the current address plus 8.
- R8: If a descriptor's length would take the frame past 2032 bytes, only the bytes up to 2032 are sent and ev_babble_o pulses with its ev_buf_o. A descriptor that contributes no bytes still gets its write-back.
- R9: A ring base write stores base_i with bits 1:0 cleared and also resets the current pointer to that value. A write made while a walk is in progress is ignored.
- R10: A doorbell accepted while a walk is in progress is remembered. When the walk reaches a non-ready descriptor, the engine reads that descriptor again before going idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable; gates doorbells |
| doorbell_i | input | 1 | Start or resume a ring walk |
| base_we_i | input | 1 | Ring base write strobe |
| base_i | input | AW | Ring base address value |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | AW | Byte address of the word access |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access done; read data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_data_o | output | 8 | Frame byte |
| tx_sof_o | output | 1 | First byte of a frame |
| tx_eof_o | output | 1 | Final byte of a frame |
| ev_buf_o | output | 1 | Descriptor completed |
| ev_frame_o | output | 1 | Frame completed |
| ev_babble_o | output | 1 | Descriptor truncated at the frame limit |

## Verification
A stale or wrong descriptor pointer appears on the memory bus at once. The next header read or write-back goes to the wrong address, and the memory model catches it on that access. A wrong running frame count shows up within the same descriptor, as a misplaced start marker or a truncation at the wrong byte. A lost remembered doorbell leaves a re-armed descriptor untouched, so expected bytes never arrive and the bench finds its queues still full once the bus goes quiet.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LANES     = WORD_W / 8;
  localparam int unsigned FLG_READY = 15;
  localparam int unsigned FLG_WRAP  = 13;
  localparam int unsigned FLG_LAST  = 11;

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] len;
  } desc_hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_HDR,
    ST_RD_PTR,
    ST_RD_DAT,
    ST_EMIT,
    ST_WB
  } walk_st_e;
endpackage

// File: rtl/tx_ring_ptr.sv
module tx_ring_ptr #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DESC_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  input  logic          idle_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  logic [AW-1:0] base_q, ptr_q;

  // R9: base writes land only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (base_we_i && idle_i) begin
      base_q <= {base_i[AW-1:2], 2'b00};
      ptr_q  <= {base_i[AW-1:2], 2'b00};
    end else if (adv_i) begin
      ptr_q <= wrap_i ? base_q : ptr_q + STEP;
    end
  end

  assign base_o = base_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/tx_ring_lanes.sv
module tx_ring_lanes #(
  parameter int unsigned LANES  = 4,
  localparam int unsigned LW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned DW    = LANES * 8
) (
  input  logic [DW-1:0] word_i,
  input  logic [LW-1:0] lane_i,
  output logic [7:0]    byte_o
);
  logic [7:0] lane_byte [LANES];

  // lane 0 is the most significant byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = word_i[DW-1-8*g -: 8];
  end

  assign byte_o = lane_byte[lane_i];
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
  import tx_ring_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MAX_FRAME = 2032,
  localparam int unsigned LW       = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              doorbell_i,
  input  logic [AW-1:0]     ptr_i,
  output logic              idle_o,
  output logic              adv_o,
  output logic              wrap_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic [LW-1:0]     lane_o,
  output logic              tx_valid_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o,
  output logic              ev_buf_o,
  output logic              ev_frame_o,
  output logic              ev_babble_o
);
  localparam logic [LEN_W-1:0] CAP      = LEN_W'(MAX_FRAME);
  localparam logic [LW-1:0]    LANE_END = LW'(LANES - 1);
  localparam logic [AW-1:0]    WSTEP    = AW'(LANES);

  walk_st_e          st_q;
  desc_hdr_t         hdr_q;
  logic [AW-1:0]     baddr_q;
  logic [LEN_W-1:0]  rem_q, fcnt_q;
  logic [WORD_W-1:0] word_q;
  logic [LW-1:0]     lane_q;
  logic              pend_q, trunc_q;
  logic              ev_buf_q, ev_frame_q, ev_babble_q;

  logic              db_ok, go;
  logic [LEN_W-1:0]  room, hdr_len, take;
  logic              over;
  logic [15:0]       fl_clr;

  assign db_ok   = doorbell_i && en_i; // R2
  assign go      = db_ok || pend_q;
  assign room    = CAP - fcnt_q;
  assign hdr_len = LEN_W'(hdr_q.len);
  assign over    = hdr_len > room; // R8
  assign take    = over ? room : hdr_len;

  always_comb begin
    fl_clr = hdr_q.flags;
    fl_clr[FLG_READY] = 1'b0; // R5
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = ptr_i;
    unique case (st_q)
      ST_RD_HDR: mem_req_o = 1'b1;
      ST_RD_PTR: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr_i + AW'(4);
      end
      ST_RD_DAT: begin
        mem_req_o  = 1'b1;
        mem_addr_o = baddr_q;
      end
      ST_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_wdata_o = {fl_clr, hdr_q.len};
  assign idle_o      = (st_q == ST_IDLE);
  assign adv_o       = (st_q == ST_WB) && mem_ack_i;
  assign wrap_o      = hdr_q.flags[FLG_WRAP]; // R7

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      hdr_q   <= '0;
      baddr_q <= '0;
      rem_q   <= '0;
      fcnt_q  <= '0;
      word_q  <= '0;
      lane_q  <= '0;
      pend_q  <= 1'b0;
      trunc_q <= 1'b0;
    end else begin
      // R10: remember doorbells seen mid-walk
      if (st_q != ST_IDLE && db_ok) pend_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          pend_q <= 1'b0;
          if (go) st_q <= ST_RD_HDR;
        end
        ST_RD_HDR: if (mem_ack_i) begin
          hdr_q <= desc_hdr_t'(mem_rdata_i);
          if (!mem_rdata_i[16+FLG_READY]) begin // R4
            pend_q <= db_ok;
            st_q   <= pend_q ? ST_RD_HDR : ST_IDLE;
          end else begin
            st_q <= ST_RD_PTR;
          end
        end
        ST_RD_PTR: if (mem_ack_i) begin
          baddr_q <= {mem_rdata_i[AW-1:2], 2'b00}; // R3
          rem_q   <= take;
          trunc_q <= over;
          st_q    <= (take == '0) ? ST_WB : ST_RD_DAT;
        end
        ST_RD_DAT: if (mem_ack_i) begin
          word_q <= mem_rdata_i;
          lane_q <= '0;
          st_q   <= ST_EMIT;
        end
        ST_EMIT: begin
          rem_q  <= rem_q - 1'b1;
          fcnt_q <= fcnt_q + 1'b1;
          lane_q <= lane_q + 1'b1;
          if (rem_q == LEN_W'(1)) begin
            st_q <= ST_WB;
          end else if (lane_q == LANE_END) begin
            baddr_q <= baddr_q + WSTEP;
            st_q    <= ST_RD_DAT;
          end
        end
        ST_WB: if (mem_ack_i) begin
          if (hdr_q.flags[FLG_LAST]) fcnt_q <= '0; // R6
          st_q <= ST_RD_HDR;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_buf_q    <= 1'b0;
      ev_frame_q  <= 1'b0;
      ev_babble_q <= 1'b0;
    end else begin
      ev_buf_q    <= adv_o;
      ev_frame_q  <= adv_o && hdr_q.flags[FLG_LAST];
      ev_babble_q <= adv_o && trunc_q;
    end
  end

  assign word_o      = word_q;
  assign lane_o      = lane_q;
  assign tx_valid_o  = (st_q == ST_EMIT);
  assign tx_sof_o    = tx_valid_o && (fcnt_q == '0);
  assign tx_eof_o    = tx_valid_o && hdr_q.flags[FLG_LAST] && (rem_q == LEN_W'(1));
  assign ev_buf_o    = ev_buf_q;
  assign ev_frame_o  = ev_frame_q;
  assign ev_babble_o = ev_babble_q;
endmodule

// File: rtl/tx_ring_dma.sv
module tx_ring_dma
  import tx_ring_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MAX_FRAME = 2032
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              doorbell_i,
  input  logic              base_we_i,
  input  logic [AW-1:0]     base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o,
  output logic              ev_buf_o,
  output logic              ev_frame_o,
  output logic              ev_babble_o
);
  localparam int unsigned LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic              idle, adv, wrap;
  logic [AW-1:0]     base, ptr;
  logic [WORD_W-1:0] word;
  logic [LW-1:0]     lane;

  tx_ring_ptr #(.AW(AW), .DESC_BYTES(8)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .base_we_i(base_we_i),
    .base_i   (base_i),
    .idle_i   (idle),
    .adv_i    (adv),
    .wrap_i   (wrap),
    .base_o   (base),
    .ptr_o    (ptr)
  );

  tx_ring_walker #(.AW(AW), .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .doorbell_i (doorbell_i),
    .ptr_i      (ptr),
    .idle_o     (idle),
    .adv_o      (adv),
    .wrap_o     (wrap),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .word_o     (word),
    .lane_o     (lane),
    .tx_valid_o (tx_valid_o),
    .tx_sof_o   (tx_sof_o),
    .tx_eof_o   (tx_eof_o),
    .ev_buf_o   (ev_buf_o),
    .ev_frame_o (ev_frame_o),
    .ev_babble_o(ev_babble_o)
  );

  tx_ring_lanes #(.LANES(LANES)) u_lanes (
    .word_i(word),
    .lane_i(lane),
    .byte_o(tx_data_o)
  );

  logic unused_base;
  assign unused_base = ^base;
endmodule

// File: rtl/tx_ring_dma_chk.sv
module tx_ring_dma_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          tx_valid_o,
  input logic          ev_buf_o,
  input logic          ev_frame_o,
  input logic          ev_babble_o
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R3

  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R9

  AST_NO_BUS_WHILE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !mem_req_o); // R3

  AST_WB_CLEARS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]); // R5

  AST_EV_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_buf_o |-> $past(mem_req_o && mem_we_o && mem_ack_i)); // R5

  AST_FRAME_ON_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_frame_o |-> ev_buf_o); // R6

  AST_BABBLE_ON_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_babble_o |-> ev_buf_o); // R8
endmodule

bind tx_ring_dma tx_ring_dma_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ack_i  (mem_ack_i),
  .tx_valid_o (tx_valid_o),
  .ev_buf_o   (ev_buf_o),
  .ev_frame_o (ev_frame_o),
  .ev_babble_o(ev_babble_o)
);

// File: tb/tx_ring_dma_test.sv
module tx_ring_dma_test;
  localparam int CAP = 2032;
  localparam logic [31:0] F_RDY  = 32'h8000_0000;
  localparam logic [31:0] F_WRAP = 32'h2000_0000;
  localparam logic [31:0] F_LAST = 32'h0800_0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni = 1'b0, en_i = 1'b0, doorbell_i = 1'b0, base_we_i = 1'b0;
  logic [31:0] base_i = '0;
  logic mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic tx_valid_o, tx_sof_o, tx_eof_o, ev_buf_o, ev_frame_o, ev_babble_o;
  logic [7:0] tx_data_o;

  tx_ring_dma uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .doorbell_i(doorbell_i),
    .base_we_i(base_we_i), .base_i(base_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_sof_o(tx_sof_o),
    .tx_eof_o(tx_eof_o), .ev_buf_o(ev_buf_o), .ev_frame_o(ev_frame_o),
    .ev_babble_o(ev_babble_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] mem_w [int unsigned];
  logic [31:0] ref_w [int unsigned];
  logic [9:0]  exp_b [$];   // {sof, eof, byte}
  logic [1:0]  exp_ev [$];  // {frame, babble}
  logic [63:0] exp_wr [$];  // {addr, data}

  int unsigned m_base = 0, m_ptr = 0, m_fcnt = 0;
  int lat = 1, wcnt = 0;
  bit hook_on = 0;
  int unsigned hook_addr = 0;
  logic [31:0] hook_val = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] patb(int unsigned a);
    return a[7:0] ^ a[15:8] ^ 8'h5a;
  endfunction

  function automatic logic [31:0] patw(int unsigned a);
    return {patb(a), patb(a + 1), patb(a + 2), patb(a + 3)};
  endfunction

  function automatic logic [31:0] ref_rd(int unsigned a);
    if (ref_w.exists(a >> 2)) return ref_w[a >> 2];
    return patw(a & ~32'h3);
  endfunction

  task automatic put_desc(int unsigned a, logic [31:0] fl, int unsigned len, int unsigned bp);
    logic [31:0] w0;
    w0 = fl | (len & 32'hffff);
    mem_w[a >> 2] = w0;       ref_w[a >> 2] = w0;
    mem_w[(a >> 2) + 1] = bp; ref_w[(a >> 2) + 1] = bp;
  endtask

  // reference walk over the bench's own copy of memory
  task automatic model_walk();
    logic [31:0] w0, w1;
    int unsigned len, room, take, bp;
    bit last, bab;
    forever begin
      w0 = ref_rd(m_ptr);
      if (!w0[31]) break;
      w1 = ref_rd(m_ptr + 4);
      len  = w0[15:0];
      last = w0[27];
      room = CAP - m_fcnt;
      bab  = len > room;
      take = bab ? room : len;
      bp   = w1 & ~32'h3;
      for (int i = 0; i < take; i++)
        exp_b.push_back({(m_fcnt == 0 && i == 0), (last && i == take - 1), patb(bp + i)});
      exp_wr.push_back({m_ptr, w0 & ~F_RDY});
      ref_w[m_ptr >> 2] = w0 & ~F_RDY;
      exp_ev.push_back({last, bab});
      m_fcnt = last ? 0 : m_fcnt + take;
      m_ptr  = w0[29] ? m_base : m_ptr + 8;
    end
  endtask

  task automatic set_base(logic [31:0] v);
    @(negedge clk); base_we_i = 1'b1; base_i = v;
    @(negedge clk); base_we_i = 1'b0;
  endtask

  task automatic pulse_db();
    @(negedge clk); doorbell_i = 1'b1;
    @(negedge clk); doorbell_i = 1'b0;
  endtask

  task automatic ring();
    en_i = 1'b1;
    model_walk();
    pulse_db();
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 40) begin
      @(negedge clk);
      q = (mem_req_o || tx_valid_o) ? 0 : q + 1;
    end
  endtask

  task automatic drained(string req);
    chk(exp_b.size() == 0, req, "bytes left", exp_b.size(), 0);
    chk(exp_ev.size() == 0, req, "events left", exp_ev.size(), 0);
    chk(exp_wr.size() == 0, req, "write-backs left", exp_wr.size(), 0);
  endtask

  // per-clock compare and memory responder
  always @(negedge clk) begin
    logic [9:0] eb;
    logic [1:0] ee;
    logic [63:0] ew;
    if (rst_ni) begin
      if (tx_valid_o) begin
        if (exp_b.size() == 0) chk(0, "R3", "unexpected byte", tx_data_o, 0);
        else begin
          eb = exp_b.pop_front();
          chk(tx_data_o == eb[7:0], "R3", "byte", tx_data_o, eb[7:0]);
          chk(tx_sof_o == eb[9], "R6", "sof", tx_sof_o, eb[9]);
          chk(tx_eof_o == eb[8], "R6", "eof", tx_eof_o, eb[8]);
        end
      end
      if (ev_buf_o) begin
        if (exp_ev.size() == 0) chk(0, "R5", "unexpected ev_buf", 1, 0);
        else begin
          ee = exp_ev.pop_front();
          chk(ev_frame_o == ee[1], "R6", "ev_frame", ev_frame_o, ee[1]);
          chk(ev_babble_o == ee[0], "R8", "ev_babble", ev_babble_o, ee[0]);
        end
      end else if (ev_frame_o || ev_babble_o) begin
        chk(0, "R5", "event without ev_buf", 1, 0);
      end
    end
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o && rst_ni) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        mem_ack_i = 1'b1;
        if (mem_we_o) begin
          if (exp_wr.size() == 0) chk(0, "R5", "unexpected write", mem_addr_o, 0);
          else begin
            ew = exp_wr.pop_front();
            chk(mem_addr_o == ew[63:32], "R7", "write-back address", mem_addr_o, ew[63:32]);
            chk(mem_wdata_o == ew[31:0], "R5", "write-back data", mem_wdata_o, ew[31:0]);
          end
          mem_w[mem_addr_o >> 2] = mem_wdata_o;
        end else begin
          mem_rdata_i = mem_w.exists(mem_addr_o >> 2) ? mem_w[mem_addr_o >> 2]
                                                       : patw(mem_addr_o);
          if (hook_on && mem_addr_o == hook_addr) begin
            mem_w[hook_addr >> 2] = hook_val;
            hook_on = 0;
          end
        end
      end else begin
        wcnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int reqs;
    // R1: quiet during and after reset
    repeat (3) @(negedge clk);
    chk(!mem_req_o && !tx_valid_o && !tx_sof_o && !tx_eof_o, "R1", "outputs in reset",
        {mem_req_o, tx_valid_o, tx_sof_o, tx_eof_o}, 0);
    chk(!ev_buf_o && !ev_frame_o && !ev_babble_o, "R1", "events in reset",
        {ev_buf_o, ev_frame_o, ev_babble_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!mem_req_o && !tx_valid_o, "R1", "outputs after reset", {mem_req_o, tx_valid_o}, 0);

    // R9: low bits dropped; R2: doorbell with enable low is ignored
    set_base(32'h0000_1003);
    m_base = 32'h1000; m_ptr = m_base;
    put_desc(32'h1000, F_RDY | F_LAST, 5, 32'h8000);
    put_desc(32'h1008, F_RDY, 8, 32'h8100);
    put_desc(32'h1010, F_RDY | F_LAST | F_WRAP, 3, 32'h8200);
    put_desc(32'h1018, F_RDY | F_LAST, 4, 32'h8300);
    en_i = 1'b0;
    pulse_db();
    reqs = 0;
    repeat (30) begin @(negedge clk); if (mem_req_o) reqs++; end
    chk(reqs == 0, "R2", "requests with enable low", reqs, 0);

    // R3 R6 R7: multi-buffer frame, wrap back to cleared first descriptor
    lat = 1;
    ring();
    wait_quiet();
    drained("R7");
    put_desc(32'h1000, F_RDY | F_LAST, 6, 32'h8400);
    ring();
    wait_quiet();
    drained("R7");

    // R4: stop point kept; R3: buffer pointer low bits ignored
    set_base(32'h2000);
    m_base = 32'h2000; m_ptr = m_base;
    put_desc(32'h2000, F_RDY | F_LAST, 9, 32'h9002);
    put_desc(32'h2008, 32'h0, 0, 0);
    ring();
    wait_quiet();
    drained("R4");
    put_desc(32'h2008, F_RDY | F_LAST, 4, 32'h9100);
    put_desc(32'h2010, 32'h0, 0, 0);
    ring();
    wait_quiet();
    drained("R4");

    // R8: frame cap, truncation, zero-byte descriptor, fresh frame after
    lat = 0;
    set_base(32'h3000);
    m_base = 32'h3000; m_ptr = m_base;
    put_desc(32'h3000, F_RDY, 2000, 32'hA000);
    put_desc(32'h3008, F_RDY, 50, 32'hB000);
    put_desc(32'h3010, F_RDY | F_LAST, 10, 32'hB800);
    put_desc(32'h3018, F_RDY | F_LAST, 7, 32'hC000);
    put_desc(32'h3020, 32'h0, 0, 0);
    ring();
    wait_quiet();
    drained("R8");

    // R9: base write during a walk is ignored
    lat = 1;
    set_base(32'h4000);
    m_base = 32'h4000; m_ptr = m_base;
    put_desc(32'h4000, F_RDY | F_LAST, 12, 32'hD000);
    put_desc(32'h4008, 32'h0, 0, 0);
    put_desc(32'h5000, F_RDY | F_LAST, 5, 32'hE000);
    put_desc(32'h5008, 32'h0, 0, 0);
    ring();
    repeat (3) @(negedge clk);
    base_we_i = 1'b1; base_i = 32'h5000;
    @(negedge clk); base_we_i = 1'b0;
    wait_quiet();
    drained("R9");
    put_desc(32'h4008, F_RDY | F_LAST, 4, 32'hD100);
    put_desc(32'h4010, 32'h0, 0, 0);
    ring();
    wait_quiet();
    drained("R9");

    // R10: doorbell during a walk forces a rescan of the stop descriptor
    lat = 2;
    set_base(32'h7000);
    m_base = 32'h7000; m_ptr = m_base;
    put_desc(32'h7000, F_RDY | F_LAST, 40, 32'hF000);
    put_desc(32'h7008, 32'h0, 0, 0);
    put_desc(32'h7010, 32'h0, 0, 0);
    mem_w[(32'h700C) >> 2] = 32'hF800; ref_w[(32'h700C) >> 2] = 32'hF800;
    hook_addr = 32'h7008;
    hook_val  = F_RDY | F_LAST | 32'd6;
    hook_on   = 1;
    ring();
    repeat (6) @(negedge clk);
    pulse_db();
    ref_w[32'h7008 >> 2] = hook_val;
    model_walk();
    wait_quiet();
    drained("R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule